// File: doc/BRIEF.md
# Accumulator Processor Arithmetic/Logic Unit

This is a purely combinational 8-bit arithmetic and logic unit for a small accumulator-style processor. Each evaluation takes an operation code, the accumulator, the two index registers, one operand byte and the incoming status byte. It returns a result byte, a code naming the register that should take that result, and the updated status byte. The surrounding core owns register storage, operand fetch and instruction decoding. It writes the result where the destination code says. For accumulator-mode shifts and rotates it passes the accumulator in as the operand.

The unit covers addition and subtraction with carry and signed overflow, and comparison against any of the three registers. It also covers the bitwise AND, XOR and OR operations and a bit test that leaves the accumulator alone. Further operations are left and right shifts, rotates through carry, increment and decrement of the operand, and a combined operation that ANDs the accumulator with X, subtracts the operand and sends the difference to X. Subtraction-like operations use carry as an inverted borrow. Decimal arithmetic is not provided.

Top module: `alu8_core`

## Requirements
- R1: The 4-bit operation code is: 0 add, 1 subtract, 2 compare A, 3 compare X, 4 compare Y, 5 AND, 6 XOR, 7 OR, 8 bit test, 9 shift left, 10 shift right, 11 rotate left, 12 rotate right, 13 increment, 14 decrement, 15 AND-X-subtract. The 2-bit destination code is 0 none, 1 A, 2 X, 3 operand location. Compare and bit test give 0, add, subtract and the logic operations give 1, AND-X-subtract gives 2, and shifts, rotates, increment and decrement give 3.
- R2: Add returns the low byte of A + operand + C. Status bit 0 (C) takes bit 8 of the sum. Status bit 6 (V) is set when A and the operand share a sign and the result sign differs from A's sign.
- R3: Subtract returns the low byte of A - operand - (1 - C). C is set when no borrow occurs. V is set when A and the operand differ in sign and the result sign differs from A's sign.
- R4: Compare forms register minus operand, with the register chosen by the operation code. C is set when the register is at least the operand. Z and N follow the difference, V is kept, and the destination code is none.
- R5: AND, XOR and OR combine A with the operand and write A. C and V are kept.
- R6: Bit test sets status bit 1 (Z) when A AND operand is zero. It copies operand bit 7 into status bit 7 (N) and operand bit 6 into V. C is kept and the destination code is none.
- R7: Shift left moves operand bit 7 into C and fills bit 0 with zero. Shift right moves operand bit 0 into C and fills bit 7 with zero, so N is always cleared.
- R8: Rotate left places the incoming C in bit 0 and operand bit 7 in C. Rotate right places the incoming C in bit 7 and operand bit 0 in C.
- R9: Increment and decrement return operand plus or minus one, modulo 256. C and V are kept.
- R10: AND-X-subtract returns (A AND X) - operand with no carry input. It sets C as compare does, keeps V and names X as destination.
- R11: For every operation Z is set exactly when the result byte is zero. For every operation except bit test, N equals result bit 7.
- R12: Status bits 2 to 5 always pass through unchanged. Any of C, Z, V, N that an operation does not affect also passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator value |
| x_i | input | 8 | X index register value |
| y_i | input | 8 | Y index register value |
| opnd_i | input | 8 | Operand byte |
| stat_i | input | 8 | Incoming status byte (bit 0 C, 1 Z, 6 V, 7 N) |
| res_o | output | 8 | Result byte |
| dst_o | output | 2 | Destination code for the result |
| stat_o | output | 8 | Updated status byte |

## Verification
Several flag rules are checked whenever the inputs change, each as a relation between ports. These are: pass-through of the unused status bits, Z against the result, N against result bit 7, the cleared N of a right shift, and the bit-test copies into N and V. Also checked this way are the preserved C and V of logic and step operations, the compare carry as an unsigned greater-or-equal, and the destination codes of compare and AND-X-subtract. The exact arithmetic values, overflow on signed boundaries, borrow handling when carry-in is clear and the rotate fill bits can only be shown by the bench's sweeps. Those sweeps compare every output against an independent model over full ranges of operands and both carry inputs.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int ALU_DW  = 8;
    localparam int OP_W    = 4;
    localparam int DST_W   = 2;
    localparam int STAT_W  = 8;

    localparam int ST_C = 0;
    localparam int ST_Z = 1;
    localparam int ST_V = 6;
    localparam int ST_N = 7;

    typedef logic [ALU_DW-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_ADDC    = 4'd0,
        OP_SUBB    = 4'd1,
        OP_CMPA    = 4'd2,
        OP_CMPX    = 4'd3,
        OP_CMPY    = 4'd4,
        OP_AND     = 4'd5,
        OP_XOR     = 4'd6,
        OP_OR      = 4'd7,
        OP_TEST    = 4'd8,
        OP_SHL     = 4'd9,
        OP_SHR     = 4'd10,
        OP_RTL     = 4'd11,
        OP_RTR     = 4'd12,
        OP_INCR    = 4'd13,
        OP_DECR    = 4'd14,
        OP_ANDXSUB = 4'd15
    } alu_op_e;

    typedef enum logic [DST_W-1:0] {
        DST_NONE = 2'd0,
        DST_A    = 2'd1,
        DST_X    = 2'd2,
        DST_MEM  = 2'd3
    } alu_dst_e;

    typedef enum logic [1:0] {
        SRC_ADD   = 2'd0,
        SRC_LOGIC = 2'd1,
        SRC_SHIFT = 2'd2
    } res_src_e;

    // How one operation routes its result and which flags it owns.
    typedef struct packed {
        res_src_e src;
        alu_dst_e dst;
        logic     upd_c;
        logic     upd_v;
        logic     nv_opnd;
    } op_rule_t;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    function automatic op_rule_t rule_of(alu_op_e op);
        op_rule_t r;
        r = '{src: SRC_ADD, dst: DST_NONE, upd_c: 1'b0, upd_v: 1'b0, nv_opnd: 1'b0};
        unique case (op)
            OP_ADDC, OP_SUBB: begin
                r.src = SRC_ADD; r.dst = DST_A; r.upd_c = 1'b1; r.upd_v = 1'b1;
            end
            OP_CMPA, OP_CMPX, OP_CMPY: begin
                r.src = SRC_ADD; r.dst = DST_NONE; r.upd_c = 1'b1;
            end
            OP_ANDXSUB: begin
                r.src = SRC_ADD; r.dst = DST_X; r.upd_c = 1'b1;
            end
            OP_AND, OP_XOR, OP_OR: begin
                r.src = SRC_LOGIC; r.dst = DST_A;
            end
            OP_TEST: begin
                r.src = SRC_LOGIC; r.dst = DST_NONE; r.nv_opnd = 1'b1;
            end
            OP_SHL, OP_SHR, OP_RTL, OP_RTR: begin
                r.src = SRC_SHIFT; r.dst = DST_MEM; r.upd_c = 1'b1;
            end
            OP_INCR, OP_DECR: begin
                r.src = SRC_SHIFT; r.dst = DST_MEM;
            end
            default: ;
        endcase
        return r;
    endfunction

    function automatic flags_t flags_from(logic [STAT_W-1:0] s);
        flags_t f;
        f.c = s[ST_C];
        f.z = s[ST_Z];
        f.v = s[ST_V];
        f.n = s[ST_N];
        return f;
    endfunction

    function automatic logic [STAT_W-1:0] flags_into(logic [STAT_W-1:0] s, flags_t f);
        logic [STAT_W-1:0] o;
        o       = s;
        o[ST_C] = f.c;
        o[ST_Z] = f.z;
        o[ST_V] = f.v;
        o[ST_N] = f.n;
        return o;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] lhs_i,
    input  logic [DW-1:0] rhs_i,
    input  logic          cin_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o,
    output logic          ovf_o
);
    // Ripple chain; carry[k] is the carry into bit k.
    logic [DW:0] carry;
    assign carry[0] = cin_i;

    for (genvar k = 0; k < DW; k++) begin : g_bit
        assign sum_o[k]   = lhs_i[k] ^ rhs_i[k] ^ carry[k];
        assign carry[k+1] = (lhs_i[k] & rhs_i[k]) | (carry[k] & (lhs_i[k] ^ rhs_i[k]));
    end

    assign cout_o = carry[DW];
    // Signed overflow: carry into the sign bit differs from carry out of it.
    assign ovf_o  = carry[DW] ^ carry[DW-1];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e op_i,
    input  word_t   a_i,
    input  word_t   m_i,
    output word_t   res_o
);
    always_comb begin
        unique case (op_i)
            OP_XOR:  res_o = a_i ^ m_i;
            OP_OR:   res_o = a_i | m_i;
            default: res_o = a_i & m_i;
        endcase
    end
endmodule

// File: rtl/alu8_modify.sv
module alu8_modify
    import alu8_pkg::*;
(
    input  alu_op_e op_i,
    input  word_t   m_i,
    input  logic    cin_i,
    output word_t   res_o,
    output logic    cout_o
);
    localparam int MSB = ALU_DW - 1;

    always_comb begin
        res_o  = m_i;
        cout_o = cin_i;
        unique case (op_i)
            OP_SHL: begin res_o = {m_i[MSB-1:0], 1'b0};  cout_o = m_i[MSB]; end
            OP_SHR: begin res_o = {1'b0, m_i[MSB:1]};    cout_o = m_i[0];   end
            OP_RTL: begin res_o = {m_i[MSB-1:0], cin_i}; cout_o = m_i[MSB]; end
            OP_RTR: begin res_o = {cin_i, m_i[MSB:1]};   cout_o = m_i[0];   end
            OP_INCR: res_o = m_i + word_t'(1);
            OP_DECR: res_o = m_i - word_t'(1);
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [ALU_DW-1:0] a_i,
    input  logic [ALU_DW-1:0] x_i,
    input  logic [ALU_DW-1:0] y_i,
    input  logic [ALU_DW-1:0] opnd_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [ALU_DW-1:0] res_o,
    output logic [DST_W-1:0]  dst_o,
    output logic [STAT_W-1:0] stat_o
);
    localparam int MSB = ALU_DW - 1;

    alu_op_e  op;
    op_rule_t rule;
    flags_t   f_in, f_out;

    assign op   = alu_op_e'(op_i);
    assign rule = rule_of(op);
    assign f_in = flags_from(stat_i);

    // Adder operand steering: subtraction forms lhs + ~rhs + carry.
    word_t add_l, add_r, add_s;
    logic  add_ci, add_co, add_ov;

    always_comb begin
        add_l  = a_i;
        add_r  = ~opnd_i;
        add_ci = 1'b1;
        unique case (op)
            OP_ADDC:    begin add_r = opnd_i; add_ci = f_in.c; end
            OP_SUBB:    add_ci = f_in.c;
            OP_CMPX:    add_l = x_i;
            OP_CMPY:    add_l = y_i;
            OP_ANDXSUB: add_l = a_i & x_i;
            default: ;
        endcase
    end

    alu8_addsub #(.DW(ALU_DW)) u_add (
        .lhs_i  (add_l),
        .rhs_i  (add_r),
        .cin_i  (add_ci),
        .sum_o  (add_s),
        .cout_o (add_co),
        .ovf_o  (add_ov)
    );

    word_t lg_res;
    alu8_logic u_logic (
        .op_i  (op),
        .a_i   (a_i),
        .m_i   (opnd_i),
        .res_o (lg_res)
    );

    word_t md_res;
    logic  md_co;
    alu8_modify u_mod (
        .op_i   (op),
        .m_i    (opnd_i),
        .cin_i  (f_in.c),
        .res_o  (md_res),
        .cout_o (md_co)
    );

    word_t res;
    always_comb begin
        unique case (rule.src)
            SRC_LOGIC: res = lg_res;
            SRC_SHIFT: res = md_res;
            default:   res = add_s;
        endcase
    end

    always_comb begin
        f_out   = f_in;
        f_out.z = (res == '0);
        f_out.n = res[MSB];
        if (rule.upd_c)
            f_out.c = (rule.src == SRC_SHIFT) ? md_co : add_co;
        if (rule.upd_v)
            f_out.v = add_ov;
        if (rule.nv_opnd) begin
            f_out.n = opnd_i[MSB];
            f_out.v = opnd_i[MSB-1];
        end
    end

    assign res_o  = res;
    assign dst_o  = rule.dst;
    assign stat_o = flags_into(stat_i, f_out);
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
    import alu8_pkg::*;
(
    input logic [OP_W-1:0]   op_i,
    input logic [ALU_DW-1:0] a_i,
    input logic [ALU_DW-1:0] x_i,
    input logic [ALU_DW-1:0] y_i,
    input logic [ALU_DW-1:0] opnd_i,
    input logic [STAT_W-1:0] stat_i,
    input logic [ALU_DW-1:0] res_o,
    input logic [DST_W-1:0]  dst_o,
    input logic [STAT_W-1:0] stat_o
);
    localparam int MSB = ALU_DW - 1;

    always_comb begin
        assert_rsvd_pass_R12: assert (stat_o[ST_V-1:ST_Z+1] == stat_i[ST_V-1:ST_Z+1]);
        assert_zero_flag_R11: assert (stat_o[ST_Z] == (res_o == '0));
        if (op_i != OP_TEST) begin
            assert_neg_flag_R11: assert (stat_o[ST_N] == res_o[MSB]);
        end
        if (op_i == OP_SHR) begin
            assert_shr_clears_n_R7: assert (!stat_o[ST_N]);
        end
        if (op_i == OP_TEST) begin
            assert_test_flags_R6: assert (stat_o[ST_N] == opnd_i[MSB] && stat_o[ST_V] == opnd_i[MSB-1]
                                          && stat_o[ST_Z] == ((a_i & opnd_i) == '0)
                                          && stat_o[ST_C] == stat_i[ST_C]);
        end
        if (op_i == OP_AND || op_i == OP_XOR || op_i == OP_OR) begin
            assert_logic_keeps_cv_R5: assert (stat_o[ST_C] == stat_i[ST_C] && stat_o[ST_V] == stat_i[ST_V]);
        end
        if (op_i == OP_INCR || op_i == OP_DECR) begin
            assert_step_keeps_cv_R9: assert (stat_o[ST_C] == stat_i[ST_C] && stat_o[ST_V] == stat_i[ST_V]);
        end
        if (op_i == OP_CMPA) begin
            assert_cmpa_carry_R4: assert (stat_o[ST_C] == (a_i >= opnd_i) && dst_o == DST_NONE);
        end
        if (op_i == OP_CMPX) begin
            assert_cmpx_carry_R4: assert (stat_o[ST_C] == (x_i >= opnd_i) && dst_o == DST_NONE);
        end
        if (op_i == OP_CMPY) begin
            assert_cmpy_carry_R4: assert (stat_o[ST_C] == (y_i >= opnd_i) && dst_o == DST_NONE);
        end
        if (op_i == OP_ANDXSUB) begin
            assert_axsub_dest_R10: assert (dst_o == DST_X && stat_o[ST_C] == ((a_i & x_i) >= opnd_i));
        end
    end
endmodule

bind alu8_core alu8_chk u_chk (.*);

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] C_ADD = 4'd0,  C_SUB = 4'd1,  C_CPA = 4'd2,  C_CPX = 4'd3;
    localparam logic [3:0] C_CPY = 4'd4,  C_AND = 4'd5,  C_XOR = 4'd6,  C_OR  = 4'd7;
    localparam logic [3:0] C_TST = 4'd8,  C_SHL = 4'd9,  C_SHR = 4'd10, C_RTL = 4'd11;
    localparam logic [3:0] C_RTR = 4'd12, C_INC = 4'd13, C_DEC = 4'd14, C_AXS = 4'd15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op;
    logic [7:0] a, x, y, m, st;
    logic [7:0] res;
    logic [1:0] dst;
    logic [7:0] st_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_core u0 (
        .op_i(op), .a_i(a), .x_i(x), .y_i(y), .opnd_i(m), .stat_i(st),
        .res_o(res), .dst_o(dst), .stat_o(st_o)
    );

    // Independent reference: {result, destination, status}.
    function automatic logic [17:0] model(logic [3:0] o, logic [7:0] ra, logic [7:0] rx,
                                          logic [7:0] ry, logic [7:0] rm, logic [7:0] s);
        logic [8:0] w;
        logic [7:0] r;
        logic [1:0] d;
        logic [7:0] so;
        logic       c;
        c  = s[0];
        so = s;
        r  = 8'h00;
        d  = 2'd0;
        w  = 9'h000;
        case (o)
            C_ADD: begin
                w = {1'b0, ra} + {1'b0, rm} + {8'h00, c}; r = w[7:0]; d = 2'd1;
                so[0] = w[8]; so[6] = (ra[7] == rm[7]) && (r[7] != ra[7]);
            end
            C_SUB: begin
                w = {1'b0, ra} - {1'b0, rm} - {8'h00, ~c}; r = w[7:0]; d = 2'd1;
                so[0] = ~w[8]; so[6] = (ra[7] != rm[7]) && (r[7] != ra[7]);
            end
            C_CPA, C_CPX, C_CPY: begin
                w = (o == C_CPA) ? {1'b0, ra} - {1'b0, rm} :
                    (o == C_CPX) ? {1'b0, rx} - {1'b0, rm} : {1'b0, ry} - {1'b0, rm};
                r = w[7:0]; so[0] = ~w[8];
            end
            C_AND: begin r = ra & rm; d = 2'd1; end
            C_XOR: begin r = ra ^ rm; d = 2'd1; end
            C_OR:  begin r = ra | rm; d = 2'd1; end
            C_TST: r = ra & rm;
            C_SHL: begin r = {rm[6:0], 1'b0}; so[0] = rm[7]; d = 2'd3; end
            C_SHR: begin r = {1'b0, rm[7:1]}; so[0] = rm[0]; d = 2'd3; end
            C_RTL: begin r = {rm[6:0], c};    so[0] = rm[7]; d = 2'd3; end
            C_RTR: begin r = {c, rm[7:1]};    so[0] = rm[0]; d = 2'd3; end
            C_INC: begin r = rm + 8'd1; d = 2'd3; end
            C_DEC: begin r = rm - 8'd1; d = 2'd3; end
            default: begin
                w = {1'b0, ra & rx} - {1'b0, rm}; r = w[7:0]; so[0] = ~w[8]; d = 2'd2;
            end
        endcase
        so[1] = (r == 8'h00);
        if (o == C_TST) begin
            so[7] = rm[7]; so[6] = rm[6];
        end else begin
            so[7] = r[7];
        end
        return {r, d, so};
    endfunction

    task automatic apply(input logic [3:0] o, input logic [7:0] ra, input logic [7:0] rx,
                         input logic [7:0] ry, input logic [7:0] rm, input logic [7:0] s,
                         input string req);
        logic [17:0] exp;
        op = o; a = ra; x = rx; y = ry; m = rm; st = s;
        #1;
        exp = model(o, ra, rx, ry, rm, s);
        n_cmp++;
        if ({res, dst, st_o} !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%h x=%h y=%h m=%h st=%h: got res=%h dst=%0d st=%h, expected res=%h dst=%0d st=%h",
                     req, o, ra, rx, ry, rm, s, res, dst, st_o, exp[17:10], exp[9:8], exp[7:0]);
        end
    endtask

    // Status input mixing pass-through bits with a chosen carry.
    function automatic logic [7:0] mk_st(logic [7:0] ra, logic [7:0] rm, logic c);
        logic [7:0] s;
        s = ra ^ {rm[3:0], rm[7:4]};
        s[0] = c;
        return s;
    endfunction

    task automatic t_idle();
        apply(C_ADD, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R1 idle add zero");
        apply(C_TST, 8'h00, 8'h00, 8'h00, 8'hC0, 8'h3C, "R12 R6 test pass bits");
    endtask

    task automatic t_add();
        apply(C_ADD, 8'h7F, 8'h00, 8'h00, 8'h01, 8'h00, "R2 pos overflow");
        apply(C_ADD, 8'h80, 8'h00, 8'h00, 8'h80, 8'h00, "R2 neg overflow carry");
        apply(C_ADD, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h01, "R2 carry-in wrap");
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 256; i++)
                for (int j = 0; j < 256; j++)
                    apply(C_ADD, 8'(i), 8'h00, 8'h00, 8'(j), mk_st(8'(i), 8'(j), c[0]), "R2 add sweep");
    endtask

    task automatic t_sub();
        apply(C_SUB, 8'h80, 8'h00, 8'h00, 8'h01, 8'h01, "R3 overflow");
        apply(C_SUB, 8'h05, 8'h00, 8'h00, 8'h05, 8'h00, "R3 borrow in");
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 256; i++)
                for (int j = 0; j < 256; j++)
                    apply(C_SUB, 8'(i), 8'h00, 8'h00, 8'(j), mk_st(8'(i), 8'(j), c[0]), "R3 sub sweep");
    endtask

    task automatic t_cmp();
        apply(C_CPA, 8'h40, 8'h00, 8'h00, 8'h40, 8'h40, "R4 equal keeps V");
        for (int i = 0; i < 256; i++)
            for (int j = 0; j < 256; j++)
                apply(C_CPA, 8'(i), 8'(j), 8'(i), 8'(j), mk_st(8'(i), 8'(j), j[2]), "R4 cmp A sweep");
        for (int i = 0; i < 256; i++)
            for (int j = 0; j < 256; j += 5) begin
                apply(C_CPX, 8'(j), 8'(i), 8'(255 - i), 8'(j), mk_st(8'(i), 8'(j), i[0]), "R4 cmp X");
                apply(C_CPY, 8'(j), 8'(255 - i), 8'(i), 8'(j), mk_st(8'(j), 8'(i), i[1]), "R4 cmp Y");
            end
    endtask

    task automatic t_logic();
        for (int i = 0; i < 256; i++)
            for (int j = 0; j < 256; j += 3) begin
                apply(C_AND, 8'(i), 8'h00, 8'h00, 8'(j), mk_st(8'(i), 8'(j), i[3]), "R5 and");
                apply(C_XOR, 8'(i), 8'h00, 8'h00, 8'(j), mk_st(8'(j), 8'(i), j[0]), "R5 xor");
                apply(C_OR,  8'(i), 8'h00, 8'h00, 8'(j), mk_st(8'(i), 8'(j), j[1]), "R5 or");
                apply(C_TST, 8'(i), 8'h00, 8'h00, 8'(j), mk_st(8'(j), 8'(i), i[0]), "R6 bit test");
            end
    endtask

    task automatic t_shift();
        for (int c = 0; c < 2; c++)
            for (int j = 0; j < 256; j++) begin
                apply(C_SHL, 8'(j ^ 8'h5A), 8'h00, 8'h00, 8'(j), mk_st(8'(j), 8'h33, c[0]), "R7 shift left");
                apply(C_SHR, 8'(j ^ 8'hA5), 8'h00, 8'h00, 8'(j), mk_st(8'hFF, 8'(j), c[0]), "R7 shift right");
                apply(C_RTL, 8'h00, 8'h00, 8'h00, 8'(j), mk_st(8'(j), 8'hC3, c[0]), "R8 rotate left");
                apply(C_RTR, 8'h00, 8'h00, 8'h00, 8'(j), mk_st(8'h0F, 8'(j), c[0]), "R8 rotate right");
            end
    endtask

    task automatic t_step();
        for (int c = 0; c < 2; c++)
            for (int j = 0; j < 256; j++) begin
                apply(C_INC, 8'(j), 8'h00, 8'h00, 8'(j), mk_st(8'(j), 8'(~j), c[0]), "R9 increment");
                apply(C_DEC, 8'(j), 8'h00, 8'h00, 8'(j), mk_st(8'(~j), 8'(j), c[0]), "R9 decrement");
            end
    endtask

    task automatic t_axsub();
        apply(C_AXS, 8'hF0, 8'h3C, 8'h00, 8'h30, 8'h00, "R10 equal no carry-in");
        for (int i = 0; i < 256; i++)
            for (int k = 0; k < 256; k += 7)
                for (int j = 0; j < 256; j += 11)
                    apply(C_AXS, 8'(i), 8'(k), 8'h00, 8'(j), mk_st(8'(i), 8'(j), k[0]), "R10 and-x-sub");
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_bad++;
        $display("FAIL watchdog expired: got timeout, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        op = 4'd0; a = 8'h00; x = 8'h00; y = 8'h00; m = 8'h00; st = 8'h00;
        #(CLK_PERIOD * 2 + 2);
        rst = 1'b0;
        t_idle();
        t_add();
        t_sub();
        t_cmp();
        t_logic();
        t_shift();
        t_step();
        t_axsub();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule